// File: doc/BRIEF.md
# Serial Transmitter with Deferred Disable

This block serialises bytes onto an asynchronous serial line. A one-entry holding register sits in front of a shift register, so one byte can wait while the previous frame goes out. A frame carries eight data bits. When nine-bit mode is selected it carries a ninth bit as well. That ninth bit comes from a separate control input, which is sampled at the moment the byte is accepted. Bit timing is derived from an external base-tick strobe. One bit lasts 16 base ticks, or 8 base ticks in double-speed mode.

Data enters through a valid/ready port. A byte is accepted in a cycle where `in_valid` and `in_ready` are both high. `in_ready` is high only while the transmitter is enabled and the holding register is empty. A producer holding `in_valid` high simply waits, and nothing is lost or overwritten. While the transmitter is disabled, `in_ready` stays low and offered bytes are ignored.

Dropping the enable does not cut a transmission short. The block keeps ownership of the line until the frame in flight and any byte still held have both been sent. After that it releases the pin, and its output rests high.

Top module: `serial_tx_deferred`

## Requirements
- R1: After reset `tx_out` is 1, `tx_oe` is 0, `dre` is 1, `in_ready` is 0 and `tx_done` is 0.
- R2: A byte is accepted in a cycle where `in_valid` and `in_ready` are both 1. `in_ready` is 1 only when the block is enabled and the holding register is empty. While `tx_en` is 0 (and the block is idle), offered bytes are ignored: no frame is sent and `dre` stays 1.
- R3: `dre` is 1 whenever the holding register is empty. It goes to 0 in the cycle after a byte is accepted, and it returns to 1 once that byte moves into the shift register.
- R4: A held byte moves into the shift register one cycle after the shift register becomes (or already is) idle. The start bit appears on `tx_out` in that same cycle.
- R5: A frame is a low start bit, then `in_data` bits 0 to 7 in order (LSB first), then the ninth bit if `nine_bit` is 1, then one high stop bit.
- R6: The ninth bit is the value of `bit9_in` in the accepting cycle. Later changes to `bit9_in` do not alter a byte already accepted.
- R7: Each bit lasts 16 cycles in which `base_tick` is 1. With `dbl_speed` set to 1 it lasts 8 such cycles. Cycles with `base_tick` 0 do not advance the timing.
- R8: `tx_oe` rises in the cycle after `tx_en` is set. After `tx_en` is cleared, `tx_oe` stays 1 until both the shift register and the holding register are empty, and then falls one cycle after the final `tx_done` pulse.
- R9: Whenever `tx_oe` is 0, `tx_out` is 1.
- R10: `tx_done` is a one-cycle pulse, raised in the cycle after a stop bit ends while no byte is held. It is not raised between back-to-back frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Transmitter enable |
| dbl_speed | input | 1 | 1: bit lasts 8 base ticks; 0: 16 |
| nine_bit | input | 1 | 1: frames carry a ninth data bit |
| bit9_in | input | 1 | Ninth bit value, captured on acceptance |
| base_tick | input | 1 | Base timing strobe |
| in_valid | input | 1 | Byte offered |
| in_data | input | 8 | Byte to send |
| in_ready | output | 1 | Byte can be accepted this cycle |
| dre | output | 1 | Holding register empty |
| tx_out | output | 1 | Serial line |
| tx_oe | output | 1 | Block drives the line |
| tx_done | output | 1 | Transmission complete pulse |

## Verification
The serialiser is exercised with random bytes and random ninth-bit values in all four combinations of frame length and speed. This shows whether bit order, bit count and bit period are all correct. Each random run mixes back-to-back bursts, which keep the holding register full, with frames spaced apart. This separates the hand-off path and the completion-pulse rule from single-frame behaviour. Directed cases cover the remaining features: a half-rate base tick, a ninth-bit input changed right after acceptance, writes offered while disabled, and clearing the enable with one frame in flight and one held, which shows whether the disable really waits.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  localparam int unsigned LOW_W = 8;

  typedef struct packed {
    logic             top;
    logic [LOW_W-1:0] low;
  } txword_t;

  typedef enum logic {
    SH_IDLE = 1'b0,
    SH_SEND = 1'b1
  } sh_state_t;
endpackage

// File: rtl/sertx_tick_div.sv
module sertx_tick_div #(
  parameter int unsigned OVS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  input  logic base_tick,
  input  logic dbl,
  output logic bit_end
);
  localparam int unsigned CW = (OVS > 2) ? $clog2(OVS) : 1;
  localparam logic [CW-1:0] FULL_M1 = CW'(OVS - 1);
  localparam logic [CW-1:0] HALF_M1 = CW'(OVS / 2 - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim;

  assign lim     = dbl ? HALF_M1 : FULL_M1;
  assign bit_end = run && base_tick && (cnt_q >= lim);

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt_q <= '0;
    else if (restart || !run)  cnt_q <= '0;
    else if (base_tick)        cnt_q <= (cnt_q >= lim) ? '0 : cnt_q + 1'b1;
  end

  // R7: a finished bit period restarts the tick count
  a_r7_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    bit_end |=> cnt_q == '0);
  // R7: no tick, no progress
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    run && !restart && !base_tick |=> $stable(cnt_q));
endmodule

// File: rtl/sertx_hold.sv
module sertx_hold
  import sertx_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    push,
  input  logic    pop,
  input  txword_t wr_word,
  output txword_t rd_word,
  output logic    full
);
  txword_t word_q;
  logic    full_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     full_q <= 1'b0;
    else if (push)  full_q <= 1'b1;
    else if (pop)   full_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     word_q <= '0;
    else if (push)  word_q <= wr_word;
  end

  assign rd_word = word_q;
  assign full    = full_q;

  // R2: nothing is written over a held byte
  a_r2_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full_q);
  // R4: only a held byte is handed on
  a_r4_pop_full: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> full_q);
endmodule

// File: rtl/sertx_shift.sv
module sertx_shift
  import sertx_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    load,
  input  txword_t word,
  input  logic    nine,
  input  logic    bit_end,
  output logic    busy,
  output logic    line,
  output logic    last_end
);
  localparam int unsigned FW = LOW_W + 3;
  localparam int unsigned IW = $clog2(FW + 1);

  sh_state_t      st_q;
  logic [FW-1:0]  sr_q;
  logic [IW-1:0]  idx_q;
  logic [IW-1:0]  last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= SH_IDLE;
      sr_q   <= '1;
      idx_q  <= '0;
      last_q <= '0;
    end else if (load && st_q == SH_IDLE) begin
      sr_q   <= {1'b1, (nine ? word.top : 1'b1), word.low, 1'b0};
      idx_q  <= '0;
      last_q <= nine ? IW'(FW - 1) : IW'(FW - 2);
      st_q   <= SH_SEND;
    end else if (st_q == SH_SEND && bit_end) begin
      sr_q  <= {1'b1, sr_q[FW-1:1]};
      idx_q <= idx_q + 1'b1;
      if (idx_q == last_q) st_q <= SH_IDLE;
    end
  end

  assign busy     = (st_q == SH_SEND);
  assign line     = busy ? sr_q[0] : 1'b1;
  assign last_end = busy && bit_end && (idx_q == last_q);

  // R5: bit index never runs past the stop bit
  a_r5_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> idx_q <= last_q);
  // R5: every frame opens with a low start bit
  a_r5_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !line);
endmodule

// File: rtl/serial_tx_deferred.sv
module serial_tx_deferred
  import sertx_pkg::*;
#(
  parameter int unsigned OVERSAMPLE = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_en,
  input  logic             dbl_speed,
  input  logic             nine_bit,
  input  logic             bit9_in,
  input  logic             base_tick,
  input  logic             in_valid,
  input  logic [LOW_W-1:0] in_data,
  output logic             in_ready,
  output logic             dre,
  output logic             tx_out,
  output logic             tx_oe,
  output logic             tx_done
);
  logic    active_q, done_q;
  logic    full, busy, line, last_end, bit_end;
  logic    push, load;
  txword_t held;
  txword_t wr_word;

  assign in_ready    = tx_en && active_q && !full;
  assign push        = in_valid && in_ready;
  assign load        = full && !busy;
  assign wr_word.top = bit9_in;
  assign wr_word.low = in_data;

  sertx_hold u_hold (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(load),
    .wr_word(wr_word), .rd_word(held), .full(full)
  );

  sertx_tick_div #(.OVS(OVERSAMPLE)) u_div (
    .clk(clk), .rst_n(rst_n), .run(busy), .restart(load),
    .base_tick(base_tick), .dbl(dbl_speed), .bit_end(bit_end)
  );

  sertx_shift u_shift (
    .clk(clk), .rst_n(rst_n), .load(load), .word(held), .nine(nine_bit),
    .bit_end(bit_end), .busy(busy), .line(line), .last_end(last_end)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      active_q <= tx_en || (active_q && (full || busy));
      done_q   <= last_end && !full;
    end
  end

  assign dre     = !full;
  assign tx_oe   = active_q;
  assign tx_out  = active_q ? line : 1'b1;
  assign tx_done = done_q;

  // R8: line kept while anything is still queued
  a_r8_defer: assert property (@(posedge clk) disable iff (!rst_n)
    active_q && (full || busy) |=> active_q);
  // R9: released line rests high
  a_r9_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !active_q |-> tx_out);
  // R10: completion is a single-cycle pulse
  a_r10_single: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> !tx_done);
  // R3: accepted byte makes the holding register non-empty
  a_r3_busy_after_push: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> !dre);
endmodule

// File: tb/serial_tx_deferred_tb_top.sv
module serial_tx_deferred_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_en = 1'b0, dbl_speed = 1'b0, nine_bit = 1'b0, bit9_in = 1'b0;
  logic base_tick = 1'b1, in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic in_ready, dre, tx_out, tx_oe, tx_done;

  int n_tests = 0, n_fail = 0;
  int done_cnt = 0;
  int frames_rx = 0;
  bit half_rate = 1'b0;
  logic [8:0] expq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_tx_deferred dut_i (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .dbl_speed(dbl_speed),
    .nine_bit(nine_bit), .bit9_in(bit9_in), .base_tick(base_tick),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .dre(dre), .tx_out(tx_out), .tx_oe(tx_oe), .tx_done(tx_done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int clk_per_bit();
    return (dbl_speed ? 8 : 16) * (half_rate ? 2 : 1);
  endfunction

  function automatic logic [8:0] exp_word(input logic [7:0] d, input logic b9);
    return {nine_bit ? b9 : 1'b0, d};
  endfunction

  always @(posedge clk) if (half_rate) base_tick <= ~base_tick; else base_tick <= 1'b1;

  always @(negedge clk) if (rst_n && tx_done) done_cnt++;

  // line receiver: R5, R7
  initial begin : rx_mon
    logic prev;
    prev = 1'b1;
    forever begin
      @(negedge clk);
      if (rst_n && prev && tx_out === 1'b0) begin
        int p, nb;
        logic [10:0] bits;
        logic [8:0] got, exp;
        p = clk_per_bit();
        nb = nine_bit ? 11 : 10;
        bits = '1;
        repeat (p/2 - 1) @(negedge clk);
        bits[0] = tx_out;
        for (int i = 1; i < nb; i++) begin
          repeat (p) @(negedge clk);
          bits[i] = tx_out;
        end
        got = {nine_bit ? bits[9] : 1'b0, bits[8:1]};
        frames_rx++;
        if (expq.size() == 0) begin
          chk(1'b0, "R2 unexpected frame", int'(got), 0);
        end else begin
          exp = expq.pop_front();
          chk(got == exp, "R5/R7 frame content", int'(got), int'(exp));
        end
        chk(bits[0] == 1'b0 && bits[nb-1] == 1'b1, "R5 start/stop levels",
            int'({bits[0], bits[nb-1]}), 1);
        prev = 1'b1;
      end else begin
        prev = tx_out;
      end
    end
  end

  task automatic send(input logic [7:0] d, input logic b9);
    @(negedge clk);
    bit9_in = b9;
    while (!in_ready) @(negedge clk);
    in_data = d;
    in_valid = 1'b1;
    expq.push_back(exp_word(d, b9));
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (expq.size() != 0) @(negedge clk);
    while (!tx_done) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    int d0;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(tx_out == 1 && tx_oe == 0 && dre == 1 && in_ready == 0 && tx_done == 0,
        "R1 reset state", int'({tx_out, tx_oe, dre, in_ready, tx_done}), 5'b10100);

    // R2/R9: writes while disabled are ignored
    begin
      bit bad;
      bad = 0;
      in_valid = 1'b1; in_data = 8'h3c;
      repeat (40) begin
        @(negedge clk);
        if (in_ready || !dre || !tx_out || tx_oe) bad = 1;
      end
      in_valid = 1'b0;
      chk(!bad, "R2 disabled write ignored / R9 idle high", int'(bad), 0);
    end

    // R8: enable
    tx_en = 1'b1;
    @(negedge clk);
    chk(tx_oe == 1 && in_ready == 1, "R8 enable takes line", int'({tx_oe, in_ready}), 3);

    // R3/R4 directed timing
    @(negedge clk);
    bit9_in = 1'b0; in_data = 8'ha5; in_valid = 1'b1;
    expq.push_back(exp_word(8'ha5, 1'b0));
    @(negedge clk);
    in_valid = 1'b0;
    chk(dre == 0 && tx_out == 1, "R3 dre low after accept", int'({dre, tx_out}), 1);
    @(negedge clk);
    chk(dre == 1 && tx_out == 0, "R4 load and start bit", int'({dre, tx_out}), 2);
    wait_idle();

    // R6: ninth bit captured on acceptance
    nine_bit = 1'b1;
    send(8'h5a, 1'b1);
    bit9_in = 1'b0;
    send(8'h81, 1'b0);
    bit9_in = 1'b1;
    wait_idle();
    chk(expq.size() == 0, "R6 ninth bit frames drained", expq.size(), 0);

    // random frames over all modes, bursts and spaced
    for (int cfg = 0; cfg < 4; cfg++) begin
      nine_bit  = cfg[0];
      dbl_speed = cfg[1];
      d0 = done_cnt;
      for (int k = 0; k < 4; k++)
        send(8'($urandom), 1'($urandom));
      wait_idle();
      chk(done_cnt - d0 == 1, "R10 one pulse per burst", done_cnt - d0, 1);
      d0 = done_cnt;
      for (int k = 0; k < 3; k++) begin
        send(8'($urandom), 1'($urandom));
        wait_idle();
      end
      chk(done_cnt - d0 == 3, "R10 pulse per spaced frame", done_cnt - d0, 3);
    end

    // R7: half-rate base tick
    half_rate = 1'b1;
    nine_bit = 1'b0; dbl_speed = 1'b0;
    send(8'hc3, 1'b0);
    send(8'h17, 1'b0);
    wait_idle();
    dbl_speed = 1'b1;
    send(8'h6e, 1'b0);
    wait_idle();
    half_rate = 1'b0;
    chk(expq.size() == 0, "R7 half rate frames drained", expq.size(), 0);

    // R8: deferred disable with one frame in flight, one held
    begin
      bit bad;
      bad = 0;
      nine_bit = 1'b1; dbl_speed = 1'b0;
      send(8'hf0, 1'b1);
      send(8'h0f, 1'b0);
      tx_en = 1'b0;
      chk(dre == 0 && in_ready == 0, "R8 held byte during disable", int'({dre, in_ready}), 0);
      while (!tx_done) begin
        if (tx_oe !== 1'b1) bad = 1;
        @(negedge clk);
      end
      chk(!bad && tx_oe == 1, "R8 line kept until drained", int'(bad), 0);
      chk(expq.size() == 0, "R8 both frames sent", expq.size(), 0);
      @(negedge clk);
      chk(tx_oe == 0 && tx_out == 1, "R8/R9 released after done",
          int'({tx_oe, tx_out}), 1);
    end

    // R2: disabled again, write ignored
    begin
      int f0;
      f0 = frames_rx;
      in_valid = 1'b1; in_data = 8'h99;
      repeat (300) @(negedge clk);
      in_valid = 1'b0;
      chk(frames_rx == f0 && dre == 1, "R2 write ignored after disable", frames_rx - f0, 0);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule